// File: doc/BRIEF.md
# Bit-Plane Mesh Shifter with Programmable Edges

This block holds one bit-plane for a grid of bit-serial processing elements, one bit per element, and moves the whole plane one nearest-neighbour step north, east, south or west in a single clock. Every element takes its new bit from exactly one of its four direct neighbours; there are no long links. A mode input decides what happens to bits that cross the boundary of the array. The five choices are a flat plane with zero fill, a cylinder (east-west wrap), a torus (wrap on both axes), a closed row-major spiral, and an open row-major string.

The physical array carries `SPARE` more rows than the logical array, so faulty rows can be retired. A per-row bypass mask names the retired physical rows. The remaining rows, taken in ascending physical order, form the logical array, which therefore stays rectangular. The plane is stored in physical rows, so a change of the mask changes which stored rows appear at the output.

The controller is a two-state machine. `ST_BLANK` is the state after reset, and the plane reads as zero in it. The transition `BLANK->HELD` is taken on the first load. `ST_HELD` stays in `ST_HELD`: a load replaces the plane, a step shifts it, and otherwise the plane is held. A step in `ST_BLANK` is ignored.

Top module: `mesh_shifter`

## Requirements
- R1: After reset the FSM is in ST_BLANK and plane_out is all zero; a step while in ST_BLANK leaves plane_out zero.
- R2: When load is high at a clock edge, plane_out equals load_plane from the next cycle on; load wins over a simultaneous step. The bit for logical row r, column c is at index r*COLS+c.
- R3: dir encodes 0 = north, 1 = east, 2 = south, 3 = west. For an east step, element (r,c) takes the bit of (r,c-1); for a west step, it takes the bit of (r,c+1). The result appears one cycle after the step strobe.
- R4: For a north step, element (r,c) takes the bit of (r+1,c); for a south step, it takes the bit of (r-1,c).
- R5: In flat mode (edge_mode 0, and the unused codes 5 to 7), bits that leave any edge are dropped and the vacated edge positions become zero.
- R6: In cylinder mode (edge_mode 1), east and west steps wrap within each row. North and south edges fill with zero.
- R7: In torus mode (edge_mode 2), steps wrap on both axes, so the count of ones in the plane is kept.
- R8: In spiral mode (edge_mode 3), an east step moves the last element of row r into the first element of row r+1, and the last element of the last row goes to element (0,0). A west step does the reverse. North and south wrap as in the torus.
- R9: In string mode (edge_mode 4), east and west steps follow the same row-major chain but both chain ends are open and fill with zero. North and south edges fill with zero.
- R10: Logical row i is the i-th physical row whose bypass bit is 0, counting up from physical row 0. On every load or step, bypass flags exactly SPARE rows, and the flagged rows are cleared. Changing bypass remaps plane_out to the stored physical rows at once.
- R11: With neither load nor step, the stored plane is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Replace the plane with load_plane |
| load_plane | input | LROWS*COLS | New plane, bit r*COLS+c for logical (r,c) |
| step | input | 1 | Shift the plane one step |
| dir | input | 2 | Shift direction: 0 N, 1 E, 2 S, 3 W |
| edge_mode | input | 3 | Boundary topology: 0 flat, 1 cylinder, 2 torus, 3 spiral, 4 string |
| bypass | input | LROWS+SPARE | One bit per physical row; 1 retires the row |
| plane_out | output | LROWS*COLS | Current logical plane |

## Verification
A load or a step registers at the edge where it is sampled, and its result is due on plane_out one cycle later. A mask change is combinational and is visible in the same cycle it is applied. The bench drives each operation just after a falling edge. It stamps each expected plane with the cycle count that the following rising edge will produce, and the monitor compares only at the falling edge whose cycle count matches that stamp. Every input stays stable from the drive point until that comparison is done, so remapping by the mask and shifting are both checked at the cycle the rules give.

// File: rtl/mesh_pkg.sv
package mesh_pkg;

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    typedef enum logic [2:0] {
        EDGE_FLAT   = 3'd0,
        EDGE_CYL    = 3'd1,
        EDGE_TORUS  = 3'd2,
        EDGE_SPIRAL = 3'd3,
        EDGE_STRING = 3'd4
    } edge_e;

    typedef enum logic {
        ST_BLANK = 1'b0,
        ST_HELD  = 1'b1
    } st_e;

endpackage

// File: rtl/mesh_row_map.sv
module mesh_row_map #(
    parameter int LROWS = 4,
    parameter int PROWS = 6
) (
    input  logic [PROWS-1:0]                                      bypass,
    output logic [LROWS-1:0][((PROWS > 1) ? $clog2(PROWS) : 1)-1:0] log2phys,
    output logic [PROWS-1:0][((LROWS > 1) ? $clog2(LROWS) : 1)-1:0] phys2log,
    output logic [PROWS-1:0]                                      live
);
    localparam int PIDX = (PROWS > 1) ? $clog2(PROWS) : 1;
    localparam int LIDX = (LROWS > 1) ? $clog2(LROWS) : 1;
    localparam logic [LIDX:0] LCAP = (LIDX+1)'(LROWS);

    logic [LIDX:0] cnt;

    // physical row -> logical row: count usable rows below
    always_comb begin
        cnt = '0;
        for (int p = 0; p < PROWS; p++) begin
            phys2log[p] = '0;
            live[p]     = 1'b0;
            if (!bypass[p] && (cnt < LCAP)) begin
                live[p]     = 1'b1;
                phys2log[p] = cnt[LIDX-1:0];
                cnt         = cnt + 1'b1;
            end
        end
    end

    // logical row -> physical row: search the live rows
    always_comb begin
        for (int i = 0; i < LROWS; i++) begin
            log2phys[i] = '0;
            for (int p = 0; p < PROWS; p++) begin
                if (live[p] && (phys2log[p] == LIDX'(i)))
                    log2phys[i] = PIDX'(p);
            end
        end
    end

endmodule

// File: rtl/mesh_shift_core.sv
module mesh_shift_core
    import mesh_pkg::*;
#(
    parameter int LROWS = 4,
    parameter int COLS  = 6
) (
    input  logic [LROWS*COLS-1:0] cur,
    input  logic [1:0]            dir,
    input  logic [2:0]            mode,
    output logic [LROWS*COLS-1:0] nxt
);
    localparam int NB = LROWS * COLS;

    for (genvar r = 0; r < LROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int SELF    = r * COLS + c;
            localparam int E_ROW   = r * COLS + (c + COLS - 1) % COLS;
            localparam int W_ROW   = r * COLS + (c + 1) % COLS;
            localparam int E_CHAIN = (SELF + NB - 1) % NB;
            localparam int W_CHAIN = (SELF + 1) % NB;
            localparam int N_SRC   = ((r + 1) % LROWS) * COLS + c;
            localparam int S_SRC   = ((r + LROWS - 1) % LROWS) * COLS + c;
            localparam bit AT_W    = (c == 0);
            localparam bit AT_E    = (c == COLS - 1);
            localparam bit AT_S    = (r == LROWS - 1);
            localparam bit AT_N    = (r == 0);

            logic bit_v;

            always_comb begin
                bit_v = 1'b0;
                unique case (dir_e'(dir))
                    DIR_E: begin
                        if (!AT_W) bit_v = cur[E_ROW];
                        else begin
                            unique case (mode)
                                EDGE_CYL, EDGE_TORUS: bit_v = cur[E_ROW];
                                EDGE_SPIRAL:          bit_v = cur[E_CHAIN];
                                EDGE_STRING:          bit_v = AT_N ? 1'b0 : cur[E_CHAIN];
                                default:              bit_v = 1'b0;
                            endcase
                        end
                    end
                    DIR_W: begin
                        if (!AT_E) bit_v = cur[W_ROW];
                        else begin
                            unique case (mode)
                                EDGE_CYL, EDGE_TORUS: bit_v = cur[W_ROW];
                                EDGE_SPIRAL:          bit_v = cur[W_CHAIN];
                                EDGE_STRING:          bit_v = AT_S ? 1'b0 : cur[W_CHAIN];
                                default:              bit_v = 1'b0;
                            endcase
                        end
                    end
                    DIR_N: begin
                        if (!AT_S) bit_v = cur[N_SRC];
                        else if (mode == EDGE_TORUS || mode == EDGE_SPIRAL) bit_v = cur[N_SRC];
                        else bit_v = 1'b0;
                    end
                    DIR_S: begin
                        if (!AT_N) bit_v = cur[S_SRC];
                        else if (mode == EDGE_TORUS || mode == EDGE_SPIRAL) bit_v = cur[S_SRC];
                        else bit_v = 1'b0;
                    end
                    default: bit_v = 1'b0;
                endcase
            end

            assign nxt[SELF] = bit_v;
        end
    end

endmodule

// File: rtl/mesh_shifter.sv
module mesh_shifter
    import mesh_pkg::*;
#(
    parameter int LROWS = 4,
    parameter int SPARE = 2,
    parameter int COLS  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [LROWS*COLS-1:0]    load_plane,
    input  logic                     step,
    input  logic [1:0]               dir,
    input  logic [2:0]               edge_mode,
    input  logic [LROWS+SPARE-1:0]   bypass,
    output logic [LROWS*COLS-1:0]    plane_out
);
    localparam int PROWS = LROWS + SPARE;
    localparam int PIDX  = (PROWS > 1) ? $clog2(PROWS) : 1;
    localparam int LIDX  = (LROWS > 1) ? $clog2(LROWS) : 1;

    st_e state_q, state_d;
    logic [PROWS-1:0][COLS-1:0] store_q, store_d;
    logic [PROWS-1:0][COLS-1:0] load_scat, step_scat;
    logic [LROWS-1:0][COLS-1:0] load_rows, step_rows;
    logic [LROWS-1:0][PIDX-1:0] log2phys;
    logic [PROWS-1:0][LIDX-1:0] phys2log;
    logic [PROWS-1:0]           live;
    logic [LROWS*COLS-1:0]      shifted;

    mesh_row_map #(.LROWS(LROWS), .PROWS(PROWS)) u_map (
        .bypass   (bypass),
        .log2phys (log2phys),
        .phys2log (phys2log),
        .live     (live)
    );

    // gather the logical plane out of the physical rows
    for (genvar i = 0; i < LROWS; i++) begin : g_gather
        assign plane_out[i*COLS +: COLS] = store_q[log2phys[i]];
    end

    mesh_shift_core #(.LROWS(LROWS), .COLS(COLS)) u_core (
        .cur  (plane_out),
        .dir  (dir),
        .mode (edge_mode),
        .nxt  (shifted)
    );

    assign load_rows = load_plane;
    assign step_rows = shifted;

    // scatter logical rows back into physical rows, retired rows cleared
    always_comb begin
        for (int p = 0; p < PROWS; p++) begin
            load_scat[p] = live[p] ? load_rows[phys2log[p]] : '0;
            step_scat[p] = live[p] ? step_rows[phys2log[p]] : '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
            store_q <= '0;
        end else begin
            state_q <= state_d;
            store_q <= store_d;
        end
    end

    // next state and plane
    always_comb begin
        state_d = state_q;
        store_d = store_q;
        unique case (state_q)
            ST_BLANK: begin
                if (load) begin
                    state_d = ST_HELD;
                    store_d = load_scat;
                end
            end
            ST_HELD: begin
                if (load)      store_d = load_scat;
                else if (step) store_d = step_scat;
            end
            default: begin
                state_d = ST_BLANK;
                store_d = '0;
            end
        endcase
    end

endmodule

// File: rtl/mesh_shifter_chk.sv
module mesh_shifter_chk
    import mesh_pkg::*;
#(
    parameter int LROWS = 4,
    parameter int SPARE = 2,
    parameter int COLS  = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   load,
    input logic [LROWS*COLS-1:0]  load_plane,
    input logic                   step,
    input logic [1:0]             dir,
    input logic [2:0]             edge_mode,
    input logic [LROWS+SPARE-1:0] bypass,
    input logic [LROWS*COLS-1:0]  plane_out,
    input st_e                    state_q
);

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK) |-> (plane_out == '0)); // R1

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!$stable(bypass) || plane_out == $past(load_plane))); // R2

    AST_MASK_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (load || step) |-> ($countones(bypass) == SPARE)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> (!$stable(bypass) || $stable(plane_out))); // R11

    AST_FLAT_NO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && edge_mode == EDGE_FLAT) |=>
        (!$stable(bypass) || $countones(plane_out) <= $countones($past(plane_out)))); // R5

    AST_TORUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && state_q == ST_HELD && edge_mode == EDGE_TORUS) |=>
        (!$stable(bypass) || $countones(plane_out) == $countones($past(plane_out)))); // R7

    AST_SPIRAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && state_q == ST_HELD && edge_mode == EDGE_SPIRAL) |=>
        (!$stable(bypass) || $countones(plane_out) == $countones($past(plane_out)))); // R8

endmodule

bind mesh_shifter mesh_shifter_chk #(.LROWS(LROWS), .SPARE(SPARE), .COLS(COLS)) u_chk (.*);

// File: tb/tb_mesh_shifter.sv
module tb_mesh_shifter;
    localparam int CLK_PERIOD = 10;
    localparam int LR = 4;
    localparam int SP = 2;
    localparam int C  = 6;
    localparam int PR = LR + SP;
    localparam int NB = LR * C;
    localparam logic [PR-1:0] MASK_A = 6'b010010;
    localparam logic [PR-1:0] MASK_B = 6'b100001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic [NB-1:0] load_plane = '0;
    logic step = 1'b0;
    logic [1:0] dir = 2'd0;
    logic [2:0] edge_mode = 3'd0;
    logic [PR-1:0] bypass = MASK_A;
    logic [NB-1:0] plane_out;

    int cyc = 0;
    int checks = 0;
    int bad = 0;
    bit started = 0;
    bit done = 0;

    typedef struct {
        logic [NB-1:0] exp;
        int            due;
        string         tag;
    } item_t;

    item_t q[$];
    item_t mon_it;
    logic [PR-1:0][C-1:0] m_phys = '0;

    mesh_shifter #(.LROWS(LR), .SPARE(SP), .COLS(C)) dut (
        .clk(clk), .rst_n(rst_n), .load(load), .load_plane(load_plane),
        .step(step), .dir(dir), .edge_mode(edge_mode), .bypass(bypass),
        .plane_out(plane_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [NB-1:0] gather(logic [PR-1:0] m);
        logic [NB-1:0] v = '0;
        int k = 0;
        for (int p = 0; p < PR; p++)
            if (!m[p] && k < LR) begin
                v[k*C +: C] = m_phys[p];
                k++;
            end
        return v;
    endfunction

    function automatic void scatter(logic [NB-1:0] v, logic [PR-1:0] m);
        int k = 0;
        for (int p = 0; p < PR; p++)
            if (!m[p] && k < LR) begin
                m_phys[p] = v[k*C +: C];
                k++;
            end else m_phys[p] = '0;
    endfunction

    // reference shift written from the requirements
    function automatic logic [NB-1:0] ref_shift(logic [NB-1:0] v, int d, int md);
        logic [NB-1:0] o = '0;
        for (int r = 0; r < LR; r++)
            for (int c = 0; c < C; c++) begin
                int sr = r;
                int sc = c;
                bit ok = 1;
                if (d == 1) begin
                    sc = c - 1;
                    if (sc < 0) begin
                        sc = C - 1;
                        if (md == 3) sr = (r == 0) ? LR - 1 : r - 1;
                        else if (md == 4) begin sr = r - 1; ok = (r != 0); end
                        else ok = (md == 1 || md == 2);
                    end
                end else if (d == 3) begin
                    sc = c + 1;
                    if (sc >= C) begin
                        sc = 0;
                        if (md == 3) sr = (r == LR - 1) ? 0 : r + 1;
                        else if (md == 4) begin sr = r + 1; ok = (r != LR - 1); end
                        else ok = (md == 1 || md == 2);
                    end
                end else if (d == 0) begin
                    sr = r + 1;
                    if (sr >= LR) begin sr = 0; ok = (md == 2 || md == 3); end
                end else begin
                    sr = r - 1;
                    if (sr < 0) begin sr = LR - 1; ok = (md == 2 || md == 3); end
                end
                if (ok) o[r*C + c] = v[sr*C + sc];
            end
        return o;
    endfunction

    // driver: apply one operation and push the expected plane
    task automatic do_op(bit ld, logic [NB-1:0] pl, bit st, int d, int md,
                         logic [PR-1:0] m, string tag);
        item_t it;
        @(negedge clk);
        #1;
        load = ld; load_plane = pl; step = st;
        dir = 2'(d); edge_mode = 3'(md); bypass = m;
        if (ld) begin
            scatter(pl, m);
            started = 1;
        end else if (st && started) begin
            scatter(ref_shift(gather(m), d, md), m);
        end
        it.exp = gather(m);
        it.due = cyc + 1;
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare at the falling edge the result is due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            mon_it = q.pop_front();
            checks++;
            if (plane_out !== mon_it.exp) begin
                bad++;
                $display("FAIL %s: got %h expected %h", mon_it.tag, plane_out, mon_it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (plane_out !== '0) begin
            bad++;
            $display("FAIL R1 reset: got %h expected %h", plane_out, {NB{1'b0}});
        end
        do_op(0, '0, 1, 1, 2, MASK_A, "R1 step in blank ignored");
        do_op(1, 24'h9B3E61, 0, 0, 0, MASK_A, "R2 load");
        do_op(0, '0, 1, 1, 0, MASK_A, "R3 R5 east flat");
        do_op(0, '0, 1, 3, 1, MASK_A, "R3 R6 west cylinder");
        do_op(0, '0, 1, 1, 1, MASK_A, "R6 east cylinder");
        do_op(0, '0, 1, 0, 2, MASK_A, "R4 R7 north torus");
        do_op(0, '0, 1, 2, 2, MASK_A, "R4 R7 south torus");
        do_op(0, '0, 1, 2, 0, MASK_A, "R4 R5 south flat");
        do_op(0, '0, 1, 0, 1, MASK_A, "R6 north cylinder zero fill");
        do_op(1, 24'hF0A5C3, 0, 0, 0, MASK_A, "R2 reload");
        do_op(0, '0, 1, 1, 3, MASK_A, "R8 east spiral");
        do_op(0, '0, 1, 3, 3, MASK_A, "R8 west spiral");
        do_op(0, '0, 1, 2, 3, MASK_A, "R8 south spiral");
        do_op(0, '0, 1, 1, 4, MASK_A, "R9 east string");
        do_op(0, '0, 1, 3, 4, MASK_A, "R9 west string");
        do_op(0, '0, 1, 0, 4, MASK_A, "R9 north string");
        do_op(0, '0, 1, 3, 7, MASK_A, "R5 unused code acts flat");
        do_op(1, 24'h5A69C3, 1, 1, 2, MASK_A, "R2 load beats step");
        do_op(0, '0, 0, 1, 2, MASK_A, "R11 idle hold");
        do_op(0, '0, 0, 0, 2, MASK_A, "R11 idle hold again");
        do_op(0, '0, 0, 0, 0, MASK_B, "R10 mask change remaps");
        do_op(0, '0, 1, 1, 2, MASK_B, "R10 step under new mask");
        do_op(1, 24'hFFFFFF, 0, 0, 0, MASK_B, "R10 load under new mask");
        do_op(0, '0, 0, 0, 0, MASK_A, "R10 retired rows cleared");
        do_op(0, '0, 0, 0, 0, MASK_A, "R11 final hold");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            checks++;
            bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule